// File: doc/BRIEF.md
# Command queue consumer engine

This block drains a circular queue of 128-bit commands kept in a small local entry store. Software fills entries through an entry write port, then moves the producer index forward through a small register port. While the queue-enable bit is set, the engine reads the entry at the consumer slot and decodes its 8-bit opcode. For each legal command it raises a one-cycle strobe that carries the decoded fields, and it steps the consumer index.

Each index is one bit wider than the slot number. The extra top bit is a wrap flag, so a full queue and an empty queue can be told apart. The consumer register also holds a 7-bit error code. When the engine meets an illegal opcode, it records code 1 there, leaves the consumer where it is and stops. It stays stopped until software rewrites the consumer register. Sync commands raise a separate completion strobe that carries the requested signalling mode. The invalidation work itself is done by the logic that receives the strobe.

Top module: `cmdq_engine`

## Requirements
- R1: After reset, the producer and consumer indices are 0, the error code is 0 and queue-enable is 0. No strobe is raised and `q_empty` is 1.
- R2: Register port, written on `reg_we`, read combinationally on `reg_rdata`.
  - Address 0 holds queue-enable at bit 3.
  - Address 1 holds the producer index in bits [LOG2SZ:0].
  - Address 2 holds the consumer index in bits [LOG2SZ:0] and the error code in bits 30:24.
- R3: `q_empty` is 1 when the producer and consumer are equal in all LOG2SZ+1 bits. `q_full` is 1 when the slot bits are equal and the wrap bits differ.
- R4: A command is consumed only when all three hold: queue-enable is 1, the queue is not empty, and the error code is 0. One command is consumed per cycle. `cmd_valid` rises for one cycle on the edge after each consumption. The consumer counts modulo 2^(LOG2SZ+1), so it keeps going until it equals the producer.
- R5: For each consumed command, the fields are taken from the entry (word k is entry bits 32k+31:32k):
  - `cmd_op` is word 0 bits 7:0.
  - `cmd_sid` is all of word 1.
  - `cmd_vmid` is word 1 bits 15:0.
  - `cmd_asid` is word 1 bits 31:16.
  - `cmd_addr` is word 3 in bits 63:32, then word 2 bits 31:12 in bits 31:12, with zeros below.
- R6: The legal opcodes are 0x01-0x07, 0x10-0x13, 0x18, 0x1A, 0x20-0x23, 0x28, 0x2A, 0x30, 0x40, 0x41, 0x44, 0x45 and 0x46. Every other value, including 0x00, is illegal.
- R7: On an illegal opcode the engine does three things: it sets the error code to 1 (code 2 means fetch abort and code 3 means sync failure; both are only ever written by software), it leaves the consumer unchanged, and it raises no strobe. While the error code is nonzero, nothing is consumed, and the code and index hold their values.
- R8: A software write to the consumer register loads both the index and the error code, and it takes priority over the engine in the same cycle. Writing an error code of 0 resumes consumption.
- R9: A consumed opcode 0x46 also raises `sync_valid` together with `cmd_valid`. `sync_mode` is then word 0 bits 13:12, where 0 means none, 1 means interrupt and 2 means send-event.
- R10: When `qw_en` is 1, `qw_data` is written into slot `qw_slot` of the entry store on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 producer, 2 consumer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| qw_en | input | 1 | Entry store write enable |
| qw_slot | input | LOG2SZ | Entry slot to write |
| qw_data | input | 128 | Entry contents |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | Queue full |
| cmd_valid | output | 1 | One-cycle strobe per consumed command |
| cmd_op | output | 8 | Opcode |
| cmd_sid | output | 32 | Stream identifier |
| cmd_vmid | output | 16 | Virtual machine identifier |
| cmd_asid | output | 16 | Address space identifier |
| cmd_addr | output | 64 | Assembled address |
| sync_valid | output | 1 | Sync completion strobe |
| sync_mode | output | 2 | Sync completion signalling mode |

## Verification
The bench drives the engine with five patterns:
- Commands queued while the queue is disabled. This separates gating by the enable from gating by emptiness.
- A short back-to-back burst. This shows one command per cycle and correct field slicing.
- A completely full queue that drains across the wrap point. This separates full from empty, and checks both the order across the wrap and the final index.
- Sync commands in two modes.
- Illegal opcodes (0x08 and 0x00), recovered by software rewrites of the consumer. These show the halt, the sticky code, the frozen index, and that a software-loaded nonzero code also holds the engine.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;

  localparam logic [7:0] OP_SYNC = 8'h46;
  localparam logic [6:0] ERR_ILLEGAL = 7'd1;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_PROD = 2'd1,
    RSEL_CONS = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic [7:0]  op;
    logic [31:0] sid;
    logic [15:0] vmid;
    logic [15:0] asid;
    logic [63:0] addr;
    logic [1:0]  sync_mode;
  } cmd_fields_t;

  function automatic logic op_legal(input logic [7:0] op);
    logic ok;
    case (op)
      8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
      8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
      8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A, 8'h30,
      8'h40, 8'h41, 8'h44, 8'h45, 8'h46: ok = 1'b1;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/cmdq_store.sv
`timescale 1ns/1ps
module cmdq_store #(
  parameter int LOG2SZ = 3,
  parameter int ENT_W  = 128
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LOG2SZ-1:0] wr_slot,
  input  logic [ENT_W-1:0]  wr_data,
  input  logic [LOG2SZ-1:0] rd_slot,
  output logic [ENT_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << LOG2SZ;

  logic [ENT_W-1:0] mem [DEPTH];

  // R10: entry write port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_data;
  end

  assign rd_data = mem[rd_slot];
endmodule

// File: rtl/cmdq_decode.sv
`timescale 1ns/1ps
module cmdq_decode
  import cmdq_pkg::*;
#(
  parameter int ENT_W = 128
) (
  input  logic [ENT_W-1:0] entry,
  output cmd_fields_t      fields,
  output logic             legal
);
  logic [31:0] w0, w1, w2, w3;

  always_comb begin
    w0 = entry[31:0];
    w1 = entry[63:32];
    w2 = entry[95:64];
    w3 = entry[127:96];
    fields.op        = w0[7:0];
    fields.sid       = w1;
    fields.vmid      = w1[15:0];
    fields.asid      = w1[31:16];
    fields.addr      = {w3, w2[31:12], 12'h000};
    fields.sync_mode = w0[13:12];
    legal            = op_legal(w0[7:0]);
  end
endmodule

// File: rtl/cmdq_ctrl.sv
`timescale 1ns/1ps
module cmdq_ctrl
  import cmdq_pkg::*;
#(
  parameter int LOG2SZ = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            q_en,
  input  logic            prod_we,
  input  logic [LOG2SZ:0] prod_wdata,
  input  logic            cons_we,
  input  logic [LOG2SZ:0] cons_wdata,
  input  logic [6:0]      err_wdata,
  input  logic            legal,
  output logic [LOG2SZ:0] prod,
  output logic [LOG2SZ:0] cons,
  output logic [6:0]      err,
  output logic            step,
  output logic            empty,
  output logic            full
);
  localparam int IW = LOG2SZ + 1;

  logic [IW-1:0] prod_nx, cons_nx;
  logic [6:0]    err_nx;
  logic          active, fault;

  always_comb begin
    empty   = (prod == cons);
    full    = (prod[LOG2SZ-1:0] == cons[LOG2SZ-1:0]) && (prod[LOG2SZ] != cons[LOG2SZ]);
    active  = q_en && !empty && (err == 7'd0);
    step    = active && legal;
    fault   = active && !legal;
    prod_nx = prod_we ? prod_wdata : prod;
    cons_nx = cons;
    err_nx  = err;
    if (cons_we) begin
      cons_nx = cons_wdata;
      err_nx  = err_wdata;
    end else if (step) begin
      cons_nx = cons + 1'b1;
    end else if (fault) begin
      err_nx = ERR_ILLEGAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod <= '0;
      cons <= '0;
      err  <= '0;
    end else begin
      prod <= prod_nx;
      cons <= cons_nx;
      err  <= err_nx;
    end
  end

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cons_we |=> (cons == $past(cons) || cons == $past(cons) + 1'b1));
  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 7'd0 && !cons_we) |=> ($stable(cons) && $stable(err)));
  assert_empty_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !step);
  assert_full_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/cmdq_engine.sv
`timescale 1ns/1ps
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int LOG2SZ = 3,
  parameter int ENT_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              qw_en,
  input  logic [LOG2SZ-1:0] qw_slot,
  input  logic [ENT_W-1:0]  qw_data,
  output logic              q_empty,
  output logic              q_full,
  output logic              cmd_valid,
  output logic [7:0]        cmd_op,
  output logic [31:0]       cmd_sid,
  output logic [15:0]       cmd_vmid,
  output logic [15:0]       cmd_asid,
  output logic [63:0]       cmd_addr,
  output logic              sync_valid,
  output logic [1:0]        sync_mode
);
  localparam int IW = LOG2SZ + 1;

  logic          ctrl_en, ctrl_en_nx;
  logic          prod_we, cons_we;
  logic [IW-1:0] prod, cons;
  logic [6:0]    err;
  logic          step, legal;
  logic [ENT_W-1:0] entry;
  cmd_fields_t   fields, fields_q;
  logic          valid_nx, sync_nx;

  assign prod_we = reg_we && (reg_addr == RSEL_PROD);
  assign cons_we = reg_we && (reg_addr == RSEL_CONS);

  cmdq_store #(.LOG2SZ(LOG2SZ), .ENT_W(ENT_W)) u_store (
    .clk(clk), .wr_en(qw_en), .wr_slot(qw_slot), .wr_data(qw_data),
    .rd_slot(cons[LOG2SZ-1:0]), .rd_data(entry)
  );

  cmdq_decode #(.ENT_W(ENT_W)) u_decode (
    .entry(entry), .fields(fields), .legal(legal)
  );

  cmdq_ctrl #(.LOG2SZ(LOG2SZ)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .q_en(ctrl_en),
    .prod_we(prod_we), .prod_wdata(reg_wdata[LOG2SZ:0]),
    .cons_we(cons_we), .cons_wdata(reg_wdata[LOG2SZ:0]),
    .err_wdata(reg_wdata[30:24]), .legal(legal),
    .prod(prod), .cons(cons), .err(err), .step(step),
    .empty(q_empty), .full(q_full)
  );

  always_comb begin
    ctrl_en_nx = (reg_we && reg_addr == RSEL_CTRL) ? reg_wdata[3] : ctrl_en;
    valid_nx   = step;
    sync_nx    = step && (fields.op == OP_SYNC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      cmd_valid  <= 1'b0;
      sync_valid <= 1'b0;
    end else begin
      ctrl_en    <= ctrl_en_nx;
      cmd_valid  <= valid_nx;
      sync_valid <= sync_nx;
    end
  end

  // field register, loaded only on a consumption step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fields_q <= '0;
    else if (step) fields_q <= fields;
  end

  assign cmd_op    = fields_q.op;
  assign cmd_sid   = fields_q.sid;
  assign cmd_vmid  = fields_q.vmid;
  assign cmd_asid  = fields_q.asid;
  assign cmd_addr  = fields_q.addr;
  assign sync_mode = fields_q.sync_mode;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RSEL_CTRL: reg_rdata[3] = ctrl_en;
      RSEL_PROD: reg_rdata[LOG2SZ:0] = prod;
      RSEL_CONS: begin
        reg_rdata[LOG2SZ:0] = cons;
        reg_rdata[30:24]    = err;
      end
      default: reg_rdata = '0;
    endcase
  end

  assert_strobe_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> op_legal(cmd_op));
  assert_sync_with_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |-> (cmd_valid && cmd_op == OP_SYNC));
  assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !cmd_valid);
endmodule

// File: tb/test_cmdq_engine.sv
`timescale 1ns/1ps
module test_cmdq_engine;
  localparam int LOG2SZ = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_we;
  logic [1:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         qw_en;
  logic [LOG2SZ-1:0] qw_slot;
  logic [127:0] qw_data;
  logic         q_empty, q_full, cmd_valid, sync_valid;
  logic [7:0]   cmd_op;
  logic [31:0]  cmd_sid;
  logic [15:0]  cmd_vmid, cmd_asid;
  logic [63:0]  cmd_addr;
  logic [1:0]   sync_mode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nlog = 0;
  int nsync = 0;
  logic [7:0]  log_op   [64];
  logic [31:0] log_sid  [64];
  logic [15:0] log_vmid [64];
  logic [15:0] log_asid [64];
  logic [63:0] log_addr [64];
  int          log_cyc  [64];
  logic [1:0]  log_mode [64];

  cmdq_engine #(.LOG2SZ(LOG2SZ)) i_cmdq_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .qw_en(qw_en),
    .qw_slot(qw_slot), .qw_data(qw_data), .q_empty(q_empty), .q_full(q_full),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sid(cmd_sid),
    .cmd_vmid(cmd_vmid), .cmd_asid(cmd_asid), .cmd_addr(cmd_addr),
    .sync_valid(sync_valid), .sync_mode(sync_mode)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && cmd_valid && nlog < 64) begin
      log_op[nlog] = cmd_op;   log_sid[nlog] = cmd_sid;
      log_vmid[nlog] = cmd_vmid; log_asid[nlog] = cmd_asid;
      log_addr[nlog] = cmd_addr; log_cyc[nlog] = cyc;
      nlog = nlog + 1;
    end
    if (rst_n && sync_valid && nsync < 64) begin
      log_mode[nsync] = sync_mode;
      nsync = nsync + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [127:0] mk(input logic [7:0] op, input logic [1:0] sel,
                                      input logic [31:0] w1, input logic [31:0] w2,
                                      input logic [31:0] w3);
    logic [31:0] w0;
    w0 = {18'h0, sel, 4'h0, op};
    return {w3, w2, w1, w0};
  endfunction

  task automatic put(input int slot, input logic [127:0] e);
    @(negedge clk);
    qw_en = 1'b1; qw_slot = slot[LOG2SZ-1:0]; qw_data = e;
    @(negedge clk);
    qw_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(2'd0, d); check(d == 32'h0, "R1 ctrl", d, 0);
    reg_read(2'd1, d); check(d == 32'h0, "R1 producer", d, 0);
    reg_read(2'd2, d); check(d == 32'h0, "R1 consumer", d, 0);
    check(q_empty == 1'b1 && cmd_valid == 1'b0, "R1 idle flags", {q_empty, cmd_valid}, 2'b10);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    put(0, mk(8'h03, 2'd0, 32'hABCD1234, 32'h5555F123, 32'h0000_0077));
    put(1, mk(8'h11, 2'd0, 32'h0001_0002, 32'hFFFF_FFFF, 32'h8000_0001));
    reg_write(2'd1, 32'd2);
    reg_read(2'd1, d); check(d == 32'd2, "R2 producer readback", d, 2);
    repeat (6) @(negedge clk);
    check(nlog == 0, "R4 no strobe while disabled", nlog, 0);
    reg_read(2'd2, d); check(d == 32'd0, "R4 consumer held while disabled", d, 0);
  endtask

  task automatic t_stream();
    logic [31:0] d;
    reg_write(2'd0, 32'h8);
    reg_read(2'd0, d); check(d == 32'h8, "R2 ctrl readback", d, 8);
    repeat (6) @(negedge clk);
    check(nlog == 2, "R4 burst count", nlog, 2);
    check(log_cyc[1] == log_cyc[0] + 1, "R4 one per cycle", log_cyc[1] - log_cyc[0], 1);
    check(log_op[0] == 8'h03 && log_op[1] == 8'h11, "R5 opcodes", {log_op[0], log_op[1]}, 16'h0311);
    check(log_sid[0] == 32'hABCD1234, "R5 sid", log_sid[0], 32'hABCD1234);
    check(log_vmid[0] == 16'h1234 && log_asid[0] == 16'hABCD, "R5 vmid/asid",
          {log_asid[0], log_vmid[0]}, 32'hABCD1234);
    check(log_addr[0] == 64'h0000_0077_5555_F000, "R5 address", log_addr[0], 64'h0000_0077_5555_F000);
    check(log_addr[1] == 64'h8000_0001_FFFF_F000, "R5 address high", log_addr[1], 64'h8000_0001_FFFF_F000);
    reg_read(2'd2, d); check(d == 32'd2, "R4 consumer reached producer", d, 2);
    check(q_empty == 1'b1, "R3 empty after drain", q_empty, 1);
  endtask

  task automatic t_sync();
    put(2, mk(8'h46, 2'd1, 32'h0, 32'h0, 32'h0));
    put(3, mk(8'h46, 2'd2, 32'h0, 32'h0, 32'h0));
    reg_write(2'd1, 32'd4);
    repeat (5) @(negedge clk);
    check(nsync == 2, "R9 sync strobes", nsync, 2);
    check(log_mode[0] == 2'd1 && log_mode[1] == 2'd2, "R9 sync modes",
          {log_mode[0], log_mode[1]}, 4'b0110);
  endtask

  task automatic t_full_wrap();
    logic [7:0] ops [8] = '{8'h07, 8'h10, 8'h13, 8'h18, 8'h1A, 8'h20, 8'h23, 8'h28};
    logic [31:0] d;
    int base;
    reg_write(2'd0, 32'h0);
    for (int s = 0; s < 8; s++) put(s, mk(ops[s], 2'd0, 32'(s), 32'h0, 32'h0));
    reg_write(2'd1, 32'd12);
    check(q_full == 1'b1 && q_empty == 1'b0, "R3 full flag", {q_full, q_empty}, 2'b10);
    base = nlog;
    reg_write(2'd0, 32'h8);
    repeat (12) @(negedge clk);
    check(nlog - base == 8, "R4 full drain count", nlog - base, 8);
    for (int k = 0; k < 8; k++)
      check(log_op[base + k] == ops[(k + 4) % 8], "R6 wrap order", log_op[base + k], ops[(k + 4) % 8]);
    reg_read(2'd2, d); check(d == 32'd12, "R4 consumer wrap bit", d, 12);
    check(q_empty == 1'b1 && q_full == 1'b0, "R3 empty after wrap", {q_full, q_empty}, 2'b01);
  endtask

  task automatic t_illegal();
    logic [31:0] d;
    int base;
    put(4, mk(8'h08, 2'd0, 32'h0, 32'h0, 32'h0));
    put(5, mk(8'h41, 2'd0, 32'h0, 32'h0, 32'h0));
    base = nlog;
    reg_write(2'd1, 32'd14);
    repeat (8) @(negedge clk);
    check(nlog == base, "R7 no strobe on illegal 0x08", nlog - base, 0);
    reg_read(2'd2, d); check(d == 32'h0100_000C, "R7 error code and held index", d, 32'h0100_000C);
    repeat (5) @(negedge clk);
    reg_read(2'd2, d); check(d == 32'h0100_000C, "R7 error sticky", d, 32'h0100_000C);
    reg_write(2'd2, 32'd13);
    repeat (4) @(negedge clk);
    check(nlog == base + 1 && log_op[base] == 8'h41, "R8 resume after clear", log_op[base], 8'h41);
    reg_read(2'd2, d); check(d == 32'd14, "R8 consumer after resume", d, 14);
    put(6, mk(8'h00, 2'd0, 32'h0, 32'h0, 32'h0));
    reg_write(2'd1, 32'd15);
    repeat (4) @(negedge clk);
    reg_read(2'd2, d); check(d == 32'h0100_000E, "R6 zero opcode illegal", d, 32'h0100_000E);
    put(7, mk(8'h2A, 2'd0, 32'h0, 32'h0, 32'h0));
    reg_write(2'd2, 32'h0200_000F);
    reg_write(2'd1, 32'd0);
    repeat (5) @(negedge clk);
    reg_read(2'd2, d); check(d == 32'h0200_000F, "R8 software error code halts", d, 32'h0200_000F);
    base = nlog;
    reg_write(2'd2, 32'h0000_000F);
    repeat (4) @(negedge clk);
    check(nlog == base + 1 && log_op[base] == 8'h2A, "R10 entry rewrite consumed", log_op[base], 8'h2A);
    reg_read(2'd2, d); check(d == 32'd0, "R4 consumer wraps to zero", d, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    qw_en = 1'b0; qw_slot = '0; qw_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_stream();
    t_sync();
    t_full_wrap();
    t_illegal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule